// File: doc/BRIEF.md
# Interleaved-Burst to Ascending-Slot Buffer Writer

This block steers a four-beat quadword burst from a burst-mode cache SRAM into a read prefetch buffer. The SRAM returns the beats in the processor's interleaved burst order, which begins at the requested quadword. The buffer is organised as a FIFO and can only take quadwords in ascending address order. For each beat the block drives the two cache address bits that select the quadword. It also raises one of four slot write strobes, so that every quadword lands in its own ascending-order slot.

A burst starts with a one-cycle start request that carries the starting quadword index. On the edge after the request the sequencer leaves idle. For beat k it presents the index `s XOR k`. It moves to the next beat only on a clock edge where the beat-valid input is high, so wait states from the SRAM are absorbed. After the fourth valid beat it pulses a done flag and returns to idle. A start request that arrives while a burst is running is ignored.

Top module: `burst_to_fifo_writer`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `cache_addr_o` is 0, `slot_wr_o` is 0 and `done_o` is 0.
- R2: A high `start_i` while idle captures `start_qw_i`. From the next cycle `cache_addr_o` equals that captured index (beat 0).
- R3: While busy at beat k (k = 0..3), `cache_addr_o` equals the captured index XOR k. k advances only on an edge where `beat_valid_i` is high, and `cache_addr_o` holds while it is low. When idle, `cache_addr_o` is 0.
- R4: `slot_wr_o` is one-hot exactly when the block is busy and `beat_valid_i` is high, in the same cycle. The set bit is bit number `cache_addr_o` (bit i writes ascending buffer slot i). Otherwise `slot_wr_o` is 0, including when `beat_valid_i` is high while idle.
- R5: Across one burst, each of the four slot strobes is raised exactly once, whatever the starting index.
- R6: `done_o` is high for exactly one cycle, the cycle after the fourth valid beat, and the block is idle in that cycle.
- R7: A high `start_i` while busy is ignored, together with its `start_qw_i`. The running burst continues with its original index and beat count.
- R8: A start request in the same cycle that `done_o` is high is accepted, because the block is already idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| start_qw_i | input | 2 | Index of the requested (first) quadword |
| beat_valid_i | input | 1 | The SRAM data beat is valid in this cycle |
| cache_addr_o | output | 2 | Cache quadword address bits for the current beat |
| slot_wr_o | output | 4 | Per-slot buffer write strobes, one-hot on a valid beat |
| done_o | output | 1 | One-cycle pulse after the fourth beat |

## Verification
`cache_addr_o` is due one edge after an accepted start and one edge after each valid beat. `slot_wr_o` is combinational from the present state and `beat_valid_i`, so it is due in the same cycle as the valid beat. `done_o` is due on the edge after the fourth valid beat. The bench drives inputs on the falling edge and lets them settle briefly. It then compares all three outputs against a behavioural model that holds the state as of the last rising edge. The model is updated only at the following rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/bfw_pkg.sv
// Package: shared types for the burst-to-ascending-slot writer.
// Assumes: a two-state sequencer is enough (idle / running a burst).
package bfw_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/bfw_sequencer.sv
// Module: bfw_sequencer
// Tracks one burst: captures the starting quadword index on an idle start,
// counts valid beats and pulses done after the last one.
// Assumes: the burst length is 2**IDX_W beats; start while busy is ignored.
module bfw_sequencer
    import bfw_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] start_idx_i,
    input  logic             beat_valid_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] start_idx_o,
    output logic [IDX_W-1:0] beat_idx_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_BEAT = '1;

    seq_state_e       state_q;
    logic [IDX_W-1:0] start_idx_q;
    logic [IDX_W-1:0] beat_q;
    logic             done_q;
    logic             last_beat;

    // Purpose: flag the valid beat that closes the burst.
    always_comb begin
        last_beat = (state_q == ST_BUSY) && beat_valid_i && (beat_q == LAST_BEAT);
    end

    // Purpose: state, captured index, beat counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            start_idx_q <= '0;
            beat_q      <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= last_beat;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q     <= ST_BUSY;
                        start_idx_q <= start_idx_i;
                        beat_q      <= '0;
                    end
                end
                ST_BUSY: begin
                    if (beat_valid_i) begin
                        if (beat_q == LAST_BEAT) begin
                            state_q <= ST_IDLE;
                            beat_q  <= '0;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: expose registered state to the datapath.
    always_comb begin
        busy_o      = (state_q == ST_BUSY);
        start_idx_o = start_idx_q;
        beat_idx_o  = beat_q;
        done_o      = done_q;
    end

endmodule

// File: rtl/bfw_addr_gen.sv
// Module: bfw_addr_gen
// Produces the interleaved burst quadword index: start index XOR beat count.
// Assumes: the output is only meaningful while busy; it is forced to 0 in idle.
module bfw_addr_gen #(
    parameter int IDX_W = 2
) (
    input  logic             busy_i,
    input  logic [IDX_W-1:0] start_idx_i,
    input  logic [IDX_W-1:0] beat_idx_i,
    output logic [IDX_W-1:0] addr_o
);

    // Purpose: interleaved order, with each address bit formed on its own.
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        always_comb begin
            addr_o[b] = busy_i & (start_idx_i[b] ^ beat_idx_i[b]);
        end
    end

endmodule

// File: rtl/bfw_slot_decoder.sv
// Module: bfw_slot_decoder
// Turns a quadword index into one of 2**IDX_W buffer slot write strobes.
// Assumes: en_i already combines "busy" and "beat valid".
module bfw_slot_decoder #(
    parameter int IDX_W = 2
) (
    input  logic                  en_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic [(1<<IDX_W)-1:0] strobe_o
);

    localparam int NUM_SLOTS = 1 << IDX_W;

    // Purpose: one comparator per ascending buffer slot.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        always_comb begin
            strobe_o[i] = en_i && (idx_i == IDX_W'(i));
        end
    end

endmodule

// File: rtl/burst_to_fifo_writer.sv
// Module: burst_to_fifo_writer (top)
// Steers a 4-beat interleaved-order burst into ascending FIFO slots:
// drives the cache quadword address per beat and the matching slot strobe.
// Assumes: beats arrive in interleaved order from the captured start index;
// synchronous active-low reset.
module burst_to_fifo_writer #(
    parameter int QW_IDX_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [QW_IDX_W-1:0]      start_qw_i,
    input  logic                     beat_valid_i,
    output logic [QW_IDX_W-1:0]      cache_addr_o,
    output logic [(1<<QW_IDX_W)-1:0] slot_wr_o,
    output logic                     done_o
);

    logic                seq_busy;
    logic [QW_IDX_W-1:0] seq_start_idx;
    logic [QW_IDX_W-1:0] beat_idx;
    logic                beat_fire;

    bfw_sequencer #(.IDX_W(QW_IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_idx_i  (start_qw_i),
        .beat_valid_i (beat_valid_i),
        .busy_o       (seq_busy),
        .start_idx_o  (seq_start_idx),
        .beat_idx_o   (beat_idx),
        .done_o       (done_o)
    );

    bfw_addr_gen #(.IDX_W(QW_IDX_W)) u_addr (
        .busy_i      (seq_busy),
        .start_idx_i (seq_start_idx),
        .beat_idx_i  (beat_idx),
        .addr_o      (cache_addr_o)
    );

    // Purpose: a strobe is due only for a valid beat of a running burst.
    always_comb begin
        beat_fire = seq_busy && beat_valid_i;
    end

    bfw_slot_decoder #(.IDX_W(QW_IDX_W)) u_dec (
        .en_i     (beat_fire),
        .idx_i    (cache_addr_o),
        .strobe_o (slot_wr_o)
    );

endmodule

// File: rtl/bfw_checker.sv
// Module: bfw_checker
// Concurrent properties for burst_to_fifo_writer, attached by bind.
// Assumes: it sees the sequencer's busy flag and beat index.
module bfw_checker #(
    parameter int QW_IDX_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic [QW_IDX_W-1:0]      start_qw_i,
    input logic                     beat_valid_i,
    input logic [QW_IDX_W-1:0]      cache_addr_o,
    input logic [(1<<QW_IDX_W)-1:0] slot_wr_o,
    input logic                     done_o,
    input logic                     busy_i,
    input logic [QW_IDX_W-1:0]      beat_idx_i
);

    localparam logic [QW_IDX_W-1:0] LAST = '1;

    p_start_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && start_i) |=> (busy_i && cache_addr_o == $past(start_qw_i)));

    p_hold_on_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !beat_valid_i) |=> (busy_i && $stable(cache_addr_o)));

    p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_wr_o));

    p_strobe_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_wr_o) |-> slot_wr_o[cache_addr_o]);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (slot_wr_o == '0));

    p_done_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && beat_valid_i && beat_idx_i == LAST) |=> (done_o && !busy_i));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && start_i && !(beat_valid_i && beat_idx_i == LAST)) |=> busy_i);

endmodule

bind burst_to_fifo_writer bfw_checker #(.QW_IDX_W(QW_IDX_W)) u_bfw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_qw_i   (start_qw_i),
    .beat_valid_i (beat_valid_i),
    .cache_addr_o (cache_addr_o),
    .slot_wr_o    (slot_wr_o),
    .done_o       (done_o),
    .busy_i       (seq_busy),
    .beat_idx_i   (beat_idx)
);

// File: tb/burst_to_fifo_writer_bench.sv
module burst_to_fifo_writer_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [1:0] start_qw_i;
    logic       beat_valid_i;
    logic [1:0] cache_addr_o;
    logic [3:0] slot_wr_o;
    logic       done_o;

    always #5 clk = ~clk;

    burst_to_fifo_writer u_burst_to_fifo_writer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_qw_i   (start_qw_i),
        .beat_valid_i (beat_valid_i),
        .cache_addr_o (cache_addr_o),
        .slot_wr_o    (slot_wr_o),
        .done_o       (done_o)
    );

    int n_checks = 0;
    int n_err    = 0;
    // behavioural reference state
    int ref_busy = 0;
    int ref_s    = 0;
    int ref_k    = 0;
    int ref_done = 0;
    int seen     = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare settled outputs, advance model at posedge.
    task automatic step(input bit st, input int qw, input bit v, input string tag);
        int exp_addr;
        int exp_wr;
        int nd;
        @(negedge clk);
        start_i      = st;
        start_qw_i   = qw[1:0];
        beat_valid_i = v;
        #1;
        exp_addr = ref_busy != 0 ? (ref_s ^ ref_k) : 0;
        exp_wr   = (ref_busy != 0 && v) ? (1 << exp_addr) : 0;
        chk(tag != "" ? tag : (ref_k == 0 ? "R2 addr" : "R3 addr"), int'(cache_addr_o), exp_addr);
        chk("R4 strobe", int'(slot_wr_o), exp_wr);
        chk("R6 done", int'(done_o), ref_done);
        if (ref_done != 0) begin
            chk("R5 slot coverage", seen, 15);
            seen = 0;
        end
        seen = seen | int'(slot_wr_o);
        @(posedge clk);
        nd = (ref_busy != 0 && v && ref_k == 3) ? 1 : 0;
        if (ref_busy == 0 && st) begin
            ref_busy = 1; ref_s = qw & 3; ref_k = 0;
        end else if (ref_busy != 0 && v) begin
            if (ref_k == 3) ref_busy = 0;
            else ref_k = ref_k + 1;
        end
        ref_done = nd;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_qw_i = 2'd0; beat_valid_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk("R1 addr", int'(cache_addr_o), 0);
        chk("R1 strobe", int'(slot_wr_o), 0);
        chk("R1 done", int'(done_o), 0);

        // R4: valid beats while idle write nothing
        step(0, 0, 1, "R4 idle valid");
        step(0, 2, 1, "R4 idle valid");

        // R3, R5: every start index, back-to-back beats
        for (int s = 0; s < 4; s++) begin
            step(1, s, 0, "");
            for (int b = 0; b < 4; b++) step(0, 0, 1, "");
            step(0, 0, 0, "R6 idle after done");
        end

        // R3: wait states between beats
        step(1, 2, 0, "");
        step(0, 0, 1, ""); step(0, 0, 0, "R3 hold"); step(0, 0, 0, "R3 hold");
        step(0, 0, 1, ""); step(0, 0, 1, ""); step(0, 0, 0, "R3 hold");
        step(0, 0, 1, ""); step(0, 0, 0, "R6 idle after done");

        // R7: start requests with another index during the burst are ignored
        step(1, 1, 0, "");
        step(1, 2, 1, "R7 start ignored");
        step(1, 3, 0, "R7 start ignored");
        step(1, 0, 1, "R7 start ignored");
        step(1, 2, 1, "R7 start ignored");
        step(0, 0, 1, "R7 start ignored");
        step(0, 0, 0, "R6 idle after done");

        // R8: start accepted in the cycle done is high
        step(1, 3, 0, "");
        for (int b = 0; b < 4; b++) step(0, 0, 1, "");
        step(1, 1, 0, "R8 restart at done");
        for (int b = 0; b < 4; b++) step(0, 0, 1, "R8 new burst");
        step(0, 0, 0, "R6 idle after done");
        step(0, 0, 0, "R1 stays idle");

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule